// File: doc/BRIEF.md
# Subarray-Aware Bank State Tracker

This block sits inside a DRAM controller and keeps state at subarray rather than bank granularity. For every subarray of every bank it stores an activated flag, the row currently raised in that subarray and a designated flag. The designated flag marks the one subarray per bank whose local row buffer is connected to the bank's shared data path.

A scheduler presents one candidate request (bank, subarray, row, direction). The request is registered. One cycle later the tracker reports which command that request needs next and whether that command may be issued now. The scheduler issues commands on a separate command port, and the table applies each one at the next clock edge. A lookup port lets the scheduler, or a test, read back any subarray's entry.

Idle subarrays of a bank that is already in use can be opened without closing the others, so rows in different subarrays of one bank can stay open together. Per-bank counters enforce the extra wait that applies after a column read or write before another subarray may be selected. All pins are plain control and status. No interface here carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `sa_bank_tracker`

## Requirements
- R1: After reset every subarray reads back as not activated, not designated and row 0, and with `req_valid` low `dec_cmd` is 0 (none) with `dec_legal` low.
- R2: A request to a subarray that is not activated yields `dec_cmd`=1 (activate), always legal. An issued activate (`cmd_kind`=1) marks the subarray activated and stores `cmd_row`.
- R3: Activating one subarray leaves the activated flag and row of every other subarray of the same bank unchanged.
- R4: A request to an activated subarray whose stored row differs from the requested row yields `dec_cmd`=2 (precharge), always legal.
- R5: A request that matches the stored row of an activated, designated subarray yields `dec_cmd`=4 (read) when `req_write` is low and 5 (write) when it is high. Both are legal and raise `dec_hit`.
- R6: A row match on an activated subarray that is not designated yields `dec_cmd`=3 (subarray select) with `dec_hit` high. An issued activate or select (`cmd_kind`=1 or 3) makes its target the only designated subarray of that bank.
- R7: An issued read (`cmd_kind`=4) or write (5) starts that bank's wait of T_RD_SA or T_WR_SA cycles. A select decision for the same bank is reported not legal until the wait has run out. Other banks are not affected.
- R8: An issued precharge (`cmd_kind`=2) clears the activated and designated flags of its subarray and of no other subarray.
- R9: With `open_row` high, a read or write leaves its subarray activated. With `open_row` low (closed-row), the read or write also clears that subarray's activated and designated flags.
- R10: Decisions reflect the request captured at the previous clock edge and the table after any command applied at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| open_row | input | 1 | 1 keeps rows open after column access, 0 closes them |
| req_valid | input | 1 | Candidate request present |
| req_bank | input | $clog2(NUM_BANKS) | Candidate bank |
| req_sa | input | $clog2(NUM_SA) | Candidate subarray |
| req_row | input | ROW_W | Candidate row within subarray |
| req_write | input | 1 | Candidate is a write |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 3 | 1 activate, 2 precharge, 3 select, 4 read, 5 write |
| cmd_bank | input | $clog2(NUM_BANKS) | Command bank |
| cmd_sa | input | $clog2(NUM_SA) | Command subarray |
| cmd_row | input | ROW_W | Row for activate |
| qry_bank | input | $clog2(NUM_BANKS) | Lookup bank |
| qry_sa | input | $clog2(NUM_SA) | Lookup subarray |
| qry_active | output | 1 | Looked-up subarray is activated |
| qry_row | output | ROW_W | Looked-up stored row |
| qry_desig | output | 1 | Looked-up subarray is designated |
| dec_cmd | output | 3 | Needed command: 0 none, codes as cmd_kind |
| dec_legal | output | 1 | Needed command may issue now |
| dec_hit | output | 1 | Request matches an open row |

## Verification
The bench uses 4 banks of 4 subarrays, 8-bit rows, a read wait of 3 and a write wait of 5. With these values every corner fits in a few cycles. The read and write waits can be told apart by the exact cycle on which a select becomes legal. One bank can sit in its wait while a second bank, already holding an open but undesignated subarray, shows that the block is per bank. With small counts the whole table can also be read back after reset.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_PRE  = 3'd2,
    CMD_SEL  = 3'd3,
    CMD_RD   = 3'd4,
    CMD_WR   = 3'd5
  } cmd_e;
endpackage

// File: rtl/sat_state_table.sv
module sat_state_table
  import sat_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int NUM_SA    = 8,
  parameter int ROW_W     = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         closed_row,
  input  logic                         cmd_valid,
  input  cmd_e                         cmd_kind,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  input  logic [$clog2(NUM_SA)-1:0]    cmd_sa,
  input  logic [ROW_W-1:0]             cmd_row,
  output logic [NUM_BANKS*NUM_SA-1:0]  act_o,
  output logic [NUM_BANKS*NUM_SA-1:0]  desg_o,
  output logic [NUM_BANKS*NUM_SA-1:0][ROW_W-1:0] row_o
);
  localparam int TOTAL  = NUM_BANKS * NUM_SA;
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int SA_W   = $clog2(NUM_SA);

  for (genvar i = 0; i < TOTAL; i++) begin : g_ent
    localparam int B = i / NUM_SA;
    localparam int S = i % NUM_SA;
    logic same_bank, self;
    assign same_bank = cmd_valid && (cmd_bank == BANK_W'(B));
    assign self      = same_bank && (cmd_sa == SA_W'(S));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_o[i]  <= 1'b0;
        desg_o[i] <= 1'b0;
        row_o[i]  <= '0;
      end else if (cmd_valid) begin
        case (cmd_kind)
          CMD_ACT: begin
            if (self) begin
              act_o[i]  <= 1'b1;
              row_o[i]  <= cmd_row;
              desg_o[i] <= 1'b1;
            end else if (same_bank) begin
              desg_o[i] <= 1'b0;
            end
          end
          CMD_SEL: begin
            if (self)           desg_o[i] <= 1'b1;
            else if (same_bank) desg_o[i] <= 1'b0;
          end
          CMD_PRE: begin
            if (self) begin
              act_o[i]  <= 1'b0;
              desg_o[i] <= 1'b0;
            end
          end
          CMD_RD, CMD_WR: begin
            if (self && closed_row) begin
              act_o[i]  <= 1'b0;
              desg_o[i] <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end

    AST_ACT_LOADS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (self && cmd_kind == CMD_ACT) |=> (act_o[i] && row_o[i] == $past(cmd_row))); // R2
    AST_PRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (self && cmd_kind == CMD_PRE) |=> (!act_o[i] && !desg_o[i])); // R8
    AST_CLOSED_RW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (self && closed_row && (cmd_kind == CMD_RD || cmd_kind == CMD_WR)) |=> !act_o[i]); // R9
    AST_DESIG_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      desg_o[i] |-> act_o[i]); // R6
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    AST_ONE_DESIG: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(desg_o[b*NUM_SA +: NUM_SA])); // R6
  end
endmodule

// File: rtl/sat_sa_timer.sv
module sat_sa_timer
  import sat_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int T_RD_SA   = 4,
  parameter int T_WR_SA   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  cmd_e                         cmd_kind,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  output logic [NUM_BANKS-1:0]         busy_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int T_MAX  = (T_RD_SA > T_WR_SA) ? T_RD_SA : T_WR_SA;
  localparam int CW     = $clog2(T_MAX + 1) < 1 ? 1 : $clog2(T_MAX + 1);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_tmr
    logic [CW-1:0] cnt;
    logic          load;
    assign load = cmd_valid && (cmd_bank == BANK_W'(g)) &&
                  (cmd_kind == CMD_RD || cmd_kind == CMD_WR);

    always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= (cmd_kind == CMD_WR) ? CW'(T_WR_SA) : CW'(T_RD_SA);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
    assign busy_o[g] = (cnt != '0);

    AST_TMR_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(1) && !load) |=> !busy_o[g]); // R7
  end
endmodule

// File: rtl/sat_decide.sv
module sat_decide
  import sat_pkg::*;
(
  input  logic req_valid,
  input  logic req_write,
  input  logic sa_active,
  input  logic row_match,
  input  logic sa_desig,
  input  logic bank_busy,
  output cmd_e need_cmd,
  output logic need_legal,
  output logic need_hit
);
  always_comb begin
    need_cmd   = CMD_NONE;
    need_legal = 1'b0;
    need_hit   = 1'b0;
    if (req_valid) begin
      if (!sa_active) begin
        need_cmd   = CMD_ACT;
        need_legal = 1'b1;
      end else if (!row_match) begin
        need_cmd   = CMD_PRE;
        need_legal = 1'b1;
      end else begin
        need_hit = 1'b1;
        if (!sa_desig) begin
          need_cmd   = CMD_SEL;
          need_legal = !bank_busy;
        end else begin
          need_cmd   = req_write ? CMD_WR : CMD_RD;
          need_legal = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sa_bank_tracker.sv
module sa_bank_tracker
  import sat_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int NUM_SA    = 8,
  parameter int ROW_W     = 9,
  parameter int T_RD_SA   = 4,
  parameter int T_WR_SA   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         open_row,
  input  logic                         req_valid,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic [$clog2(NUM_SA)-1:0]    req_sa,
  input  logic [ROW_W-1:0]             req_row,
  input  logic                         req_write,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_kind,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  input  logic [$clog2(NUM_SA)-1:0]    cmd_sa,
  input  logic [ROW_W-1:0]             cmd_row,
  input  logic [$clog2(NUM_BANKS)-1:0] qry_bank,
  input  logic [$clog2(NUM_SA)-1:0]    qry_sa,
  output logic                         qry_active,
  output logic [ROW_W-1:0]             qry_row,
  output logic                         qry_desig,
  output logic [2:0]                   dec_cmd,
  output logic                         dec_legal,
  output logic                         dec_hit
);
  localparam int TOTAL  = NUM_BANKS * NUM_SA;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int SA_W   = $clog2(NUM_SA);

  cmd_e kind;
  assign kind = cmd_e'(cmd_kind);

  logic [TOTAL-1:0]            act, desg;
  logic [TOTAL-1:0][ROW_W-1:0] rows;
  logic [NUM_BANKS-1:0]        busy;

  logic              rq_valid, rq_write;
  logic [BANK_W-1:0] rq_bank;
  logic [SA_W-1:0]   rq_sa;
  logic [ROW_W-1:0]  rq_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_valid <= 1'b0;
      rq_write <= 1'b0;
      rq_bank  <= '0;
      rq_sa    <= '0;
      rq_row   <= '0;
    end else begin
      rq_valid <= req_valid;
      rq_write <= req_write;
      rq_bank  <= req_bank;
      rq_sa    <= req_sa;
      rq_row   <= req_row;
    end
  end

  sat_state_table #(.NUM_BANKS(NUM_BANKS), .NUM_SA(NUM_SA), .ROW_W(ROW_W)) u_table (
    .clk(clk), .rst_n(rst_n), .closed_row(!open_row),
    .cmd_valid(cmd_valid), .cmd_kind(kind), .cmd_bank(cmd_bank), .cmd_sa(cmd_sa),
    .cmd_row(cmd_row), .act_o(act), .desg_o(desg), .row_o(rows)
  );

  sat_sa_timer #(.NUM_BANKS(NUM_BANKS), .T_RD_SA(T_RD_SA), .T_WR_SA(T_WR_SA)) u_timer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(kind),
    .cmd_bank(cmd_bank), .busy_o(busy)
  );

  logic [IDX_W-1:0] rq_idx, q_idx;
  assign rq_idx = IDX_W'(rq_bank) * IDX_W'(NUM_SA) + IDX_W'(rq_sa);
  assign q_idx  = IDX_W'(qry_bank) * IDX_W'(NUM_SA) + IDX_W'(qry_sa);

  assign qry_active = act[q_idx];
  assign qry_row    = rows[q_idx];
  assign qry_desig  = desg[q_idx];

  cmd_e need;
  sat_decide u_decide (
    .req_valid(rq_valid), .req_write(rq_write), .sa_active(act[rq_idx]),
    .row_match(rows[rq_idx] == rq_row), .sa_desig(desg[rq_idx]),
    .bank_busy(busy[rq_bank]), .need_cmd(need), .need_legal(dec_legal),
    .need_hit(dec_hit)
  );
  assign dec_cmd = need;

  AST_SEL_ISSUED_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && kind == CMD_SEL) |-> !busy[cmd_bank]); // R7
  AST_LEGAL_SEL_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (need == CMD_SEL && dec_legal) |-> !busy[rq_bank]); // R7
  AST_SEL_TARGET_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && kind == CMD_SEL) |-> act[IDX_W'(cmd_bank) * IDX_W'(NUM_SA) + IDX_W'(cmd_sa)]); // R6
  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !rq_valid |-> (need == CMD_NONE && !dec_legal)); // R1
endmodule

// File: tb/test_sa_bank_tracker.sv
`timescale 1ns/1ps
module test_sa_bank_tracker;
  import sat_pkg::*;
  localparam int NB = 4, NS = 4, RW = 8, TRD = 3, TWR = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, open_row = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0, req_sa = '0;
  logic [RW-1:0] req_row = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_kind = '0;
  logic [1:0] cmd_bank = '0, cmd_sa = '0;
  logic [RW-1:0] cmd_row = '0;
  logic [1:0] qry_bank = '0, qry_sa = '0;
  logic qry_active, qry_desig, dec_legal, dec_hit;
  logic [RW-1:0] qry_row;
  logic [2:0] dec_cmd;

  sa_bank_tracker #(.NUM_BANKS(NB), .NUM_SA(NS), .ROW_W(RW), .T_RD_SA(TRD), .T_WR_SA(TWR))
  i_sa_bank_tracker (
    .clk(clk), .rst_n(rst_n), .open_row(open_row),
    .req_valid(req_valid), .req_bank(req_bank), .req_sa(req_sa), .req_row(req_row),
    .req_write(req_write), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_sa(cmd_sa), .cmd_row(cmd_row),
    .qry_bank(qry_bank), .qry_sa(qry_sa), .qry_active(qry_active), .qry_row(qry_row),
    .qry_desig(qry_desig), .dec_cmd(dec_cmd), .dec_legal(dec_legal), .dec_hit(dec_hit)
  );

  int checks = 0, errors = 0;

  typedef struct { logic [2:0] cmd; logic legal; string tag; } exp_t;
  exp_t sb[$];
  event ev_sample;

  // monitor: pops expected decisions and compares with the ports
  initial forever begin
    @(ev_sample);
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (dec_cmd !== e.cmd || dec_legal !== e.legal) begin
        errors++;
        $display("FAIL %s: cmd/legal actual %0d/%0d expected %0d/%0d",
                 e.tag, dec_cmd, dec_legal, e.cmd, e.legal);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic expect_dec(input logic [2:0] c, input logic l, input string tag);
    exp_t e;
    e.cmd = c; e.legal = l; e.tag = tag;
    sb.push_back(e);
    -> ev_sample;
    #1;
  endtask

  task automatic issue(input cmd_e k, input int b, input int s, input int row);
    cmd_valid = 1'b1; cmd_kind = k; cmd_bank = 2'(b); cmd_sa = 2'(s); cmd_row = RW'(row);
    cyc();
    cmd_valid = 1'b0;
  endtask

  task automatic req(input int b, input int s, input int row, input logic wr);
    req_valid = 1'b1; req_bank = 2'(b); req_sa = 2'(s); req_row = RW'(row); req_write = wr;
    cyc();
  endtask

  task automatic tab(input int b, input int s, input logic ea, input int er,
                     input logic ed, input string tag);
    qry_bank = 2'(b); qry_sa = 2'(s);
    #1;
    checks++;
    if (qry_active !== ea || qry_desig !== ed || (ea && qry_row !== RW'(er))) begin
      errors++;
      $display("FAIL %s: b%0d s%0d act/desg/row actual %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, b, s, qry_active, qry_desig, qry_row, ea, ed, er);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1: table cleared, no request means no command
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < NS; s++)
        tab(b, s, 1'b0, 0, 1'b0, "R1 reset table");
    expect_dec(CMD_NONE, 1'b0, "R1 idle decision");

    // bank 2: subarray 0 open but not designated
    issue(CMD_ACT, 2, 0, 1);
    issue(CMD_ACT, 2, 1, 2);
    tab(2, 0, 1'b1, 1, 1'b0, "R6 act moves designation");

    // R2 / R10
    req(1, 2, 'h10, 1'b0);
    expect_dec(CMD_ACT, 1'b1, "R2 idle subarray");
    issue(CMD_ACT, 1, 2, 'h10);
    expect_dec(CMD_RD, 1'b1, "R10 decision follows table");
    tab(1, 2, 1'b1, 'h10, 1'b1, "R2 activate stores row");
    req(1, 2, 'h10, 1'b1);
    expect_dec(CMD_WR, 1'b1, "R5 write hit");

    // R3: second subarray of busy bank
    req(1, 0, 'h20, 1'b0);
    expect_dec(CMD_ACT, 1'b1, "R3 open second subarray");
    issue(CMD_ACT, 1, 0, 'h20);
    tab(1, 2, 1'b1, 'h10, 1'b0, "R3 other subarray kept");
    tab(1, 0, 1'b1, 'h20, 1'b1, "R6 sole designated");
    expect_dec(CMD_RD, 1'b1, "R5 read hit");
    req(1, 2, 'h10, 1'b0);
    expect_dec(CMD_SEL, 1'b1, "R6 select needed");

    // R7 write wait: after issue edge wait=5
    issue(CMD_WR, 1, 0, 0);
    tab(1, 0, 1'b1, 'h20, 1'b1, "R9 open-row keeps row");
    req(2, 0, 1, 1'b0);                       // wait 4
    expect_dec(CMD_SEL, 1'b1, "R7 other bank unaffected");
    req(1, 2, 'h10, 1'b0);                    // wait 3
    expect_dec(CMD_SEL, 1'b0, "R7 write wait blocks");
    cyc(); cyc();                             // wait 1
    expect_dec(CMD_SEL, 1'b0, "R7 write wait last cycle");
    cyc();                                    // wait 0
    expect_dec(CMD_SEL, 1'b1, "R7 write wait over");

    issue(CMD_SEL, 1, 2, 0);
    tab(1, 2, 1'b1, 'h10, 1'b1, "R6 select designates");
    tab(1, 0, 1'b1, 'h20, 1'b0, "R6 select clears others");
    expect_dec(CMD_RD, 1'b1, "R5 hit after select");

    // R7 read wait: 3
    issue(CMD_RD, 1, 2, 0);
    req(1, 0, 'h20, 1'b0);                    // wait 2
    expect_dec(CMD_SEL, 1'b0, "R7 read wait blocks");
    cyc();                                    // wait 1
    expect_dec(CMD_SEL, 1'b0, "R7 read wait last cycle");
    cyc();                                    // wait 0
    expect_dec(CMD_SEL, 1'b1, "R7 read wait over");

    // R4 / R8
    req(1, 2, 'h33, 1'b0);
    expect_dec(CMD_PRE, 1'b1, "R4 row conflict");
    issue(CMD_PRE, 1, 2, 0);
    tab(1, 2, 1'b0, 0, 1'b0, "R8 precharge clears");
    tab(1, 0, 1'b1, 'h20, 1'b0, "R8 neighbour untouched");
    expect_dec(CMD_ACT, 1'b1, "R8 closed subarray needs activate");

    // R9 closed-row
    open_row = 1'b0;
    issue(CMD_SEL, 1, 0, 0);
    tab(1, 0, 1'b1, 'h20, 1'b1, "R6 select before closed read");
    issue(CMD_RD, 1, 0, 0);
    tab(1, 0, 1'b0, 0, 1'b0, "R9 closed-row read closes");
    req(1, 0, 'h20, 1'b0);
    expect_dec(CMD_ACT, 1'b1, "R9 closed-row needs activate");

    req_valid = 1'b0;
    cyc();
    expect_dec(CMD_NONE, 1'b0, "R10 no request");

    #2;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d decisions left uncompared, expected 0", sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule